// File: doc/BRIEF.md
# Sub-word Atomic Memory Operation Unit

This block carries out byte and halfword atomic read-modify-write instructions for a 32-bit load/store core. The core passes it the instruction word, the address taken from rs1, the operand taken from rs2, and a flag that enables the sub-word atomic group. The unit decodes the instruction and checks it. It then locks a 32-bit word memory port and reads the word that holds the addressed lane. In the next cycle it applies the operation to that lane and writes the result back, with only that lane's byte strobes set. Finally it returns the original lane value to the destination register, sign-extended to the full width.

An encoding the unit does not accept, or any encoding while the enable flag is low, produces a one-cycle illegal-instruction pulse. A halfword at an odd address produces a one-cycle misaligned pulse. In both cases the memory port is never driven. The acquire and release bits are not interpreted: they are held on two outputs while the operation is in flight, so the surrounding fabric can order it.

Top module: `subword_amo_unit`

## Requirements
- R1: An instruction is accepted when bits 6:0 equal 0101111 and bits 14:12 equal 000 (byte) or 001 (halfword). Bit 26 (acquire) and bit 25 (release) may take any value and are presented on ord_acquire/ord_release from the read cycle through the done cycle. The destination index is taken from bits 11:7.
- R2: On completion, rd_value holds the original memory lane, sign-extended from bit 7 (byte) or bit 15 (halfword), and rd_index holds bits 11:7. Both are valid while done is high.
- R3: Bits 31:27 select the operation: 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or. Add wraps modulo the access width, and no carry is reported.
- R4: Bits 31:27 equal to 10000 select signed minimum, and 10100 selects signed maximum. Both compare the operands as two's-complement values of the access width.
- R5: Bits 31:27 equal to 11000 select unsigned minimum, and 11100 selects unsigned maximum. Both compare the operands as unsigned values of the access width.
- R6: Only the low 8 (byte) or 16 (halfword) bits of rs2 take part. The write leaves every other byte of the word unchanged. mem_strb is 1 shifted left by address bits 1:0 for a byte, and 3 shifted left by address bits 1:0 for a halfword.
- R7: While ext_enable is low, every request raises fault_illegal for one cycle, issues no memory read or write, and produces no done.
- R8: An unlisted value in bits 31:27, a value in bits 14:12 other than 000 or 001, or a different value in bits 6:0 raises fault_illegal with no memory access.
- R9: A halfword request with address bit 0 set raises fault_misaligned for one cycle, issues no memory access and produces no done. A byte request is accepted at any address.
- R10: An accepted request runs one read cycle and then one write cycle, and mem_lock is high during exactly those two cycles. done pulses for one cycle immediately after the write, with mem_lock low. busy is high from the read cycle through the done cycle.
- R11: While rst is high and directly after it, busy, done, mem_lock, mem_rd_en, mem_wr_en, fault_illegal and fault_misaligned are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_enable | input | 1 | Enables the sub-word atomic instruction group |
| req_valid | input | 1 | Request strobe, sampled only when not busy |
| req_insn | input | 32 | Instruction word |
| req_addr | input | XLEN | Byte address from rs1 |
| req_data | input | XLEN | Operand from rs2 |
| busy | output | 1 | Operation in flight |
| mem_lock | output | 1 | Holds the memory exclusive across read and write |
| mem_rd_en | output | 1 | Word read request, data returned on the next cycle |
| mem_wr_en | output | 1 | Word write request |
| mem_addr | output | XLEN | Word-aligned byte address |
| mem_rdata | input | XLEN | Read data, valid the cycle after mem_rd_en |
| mem_wdata | output | XLEN | Merged write word |
| mem_strb | output | XLEN/8 | Byte write strobes |
| ord_acquire | output | 1 | Acquire bit of the instruction in flight |
| ord_release | output | 1 | Release bit of the instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_index | output | 5 | Destination register index |
| rd_value | output | XLEN | Sign-extended old lane value |
| fault_illegal | output | 1 | One-cycle illegal-instruction pulse |
| fault_misaligned | output | 1 | One-cycle misaligned-address pulse |

## Verification
The bench builds the unit with XLEN at its default of 32, which gives four byte lanes and two halfword lanes per word. With this setting every byte offset and both halfword offsets can be reached, along with the wrap of each lane width and the sign boundary of each lane width. The operand values are chosen so that the signed and unsigned comparisons give opposite results, and so that the upper rs2 bits hold junk that must be ignored. The misaligned odd halfword offsets, 1 and 3, are also reachable with this setting.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;

  typedef enum logic [3:0] {
    AOP_ADD, AOP_SWAP, AOP_XOR, AOP_AND, AOP_OR,
    AOP_MIN, AOP_MAX, AOP_MINU, AOP_MAXU
  } amo_op_e;

  typedef enum logic {
    SZ_BYTE,
    SZ_HALF
  } amo_size_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_DONE
  } amo_state_e;

  typedef struct packed {
    logic      legal;
    amo_op_e   op;
    amo_size_e size;
    logic      acq;
    logic      rel;
    logic [4:0] rd;
  } amo_dec_t;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        ext_enable,
  output amo_dec_t    dec
);

  logic       op_ok;
  logic       size_ok;
  amo_op_e    op_sel;
  logic [9:0] unused_reg_fields;

  assign unused_reg_fields = insn[24:15];

  always_comb begin
    op_ok  = 1'b1;
    op_sel = AOP_ADD;
    unique case (insn[31:27])
      5'b00000: op_sel = AOP_ADD;
      5'b00001: op_sel = AOP_SWAP;
      5'b00100: op_sel = AOP_XOR;
      5'b01100: op_sel = AOP_AND;
      5'b01000: op_sel = AOP_OR;
      5'b10000: op_sel = AOP_MIN;
      5'b10100: op_sel = AOP_MAX;
      5'b11000: op_sel = AOP_MINU;
      5'b11100: op_sel = AOP_MAXU;
      default:  op_ok  = 1'b0;
    endcase
  end

  assign size_ok = (insn[14:13] == 2'b00);

  always_comb begin
    dec.legal = ext_enable && op_ok && size_ok && (insn[6:0] == OPC_ATOMIC);
    dec.op    = op_sel;
    dec.size  = insn[12] ? SZ_HALF : SZ_BYTE;
    dec.acq   = insn[26];
    dec.rel   = insn[25];
    dec.rd    = insn[11:7];
  end

endmodule

// File: rtl/amo_lane_alu.sv
module amo_lane_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  amo_op_e              op,
  input  amo_size_e            size,
  input  logic [OFF_W-1:0]     offset,
  input  logic [XLEN-1:0]      rdata,
  input  logic [15:0]          operand,
  output logic [XLEN-1:0]      wdata,
  output logic [XLEN/8-1:0]    wstrb,
  output logic [XLEN-1:0]      old_sext
);

  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [XLEN-1:0] shifted;
  logic [7:0]      old8;
  logic [15:0]     old16;
  logic            signed_cmp;
  logic [16:0]     a_ext;
  logic [16:0]     b_ext;
  logic            a_lt_b;
  logic [15:0]     new_val;
  logic [XLEN-17:0] unused_high;

  assign shifted     = rdata >> {offset, 3'b000};
  assign old8        = shifted[7:0];
  assign old16       = shifted[15:0];
  assign unused_high = shifted[XLEN-1:16];

  assign signed_cmp = (op == AOP_MIN) || (op == AOP_MAX);

  always_comb begin
    if (size == SZ_HALF) begin
      a_ext = {signed_cmp & old16[15], old16};
      b_ext = {signed_cmp & operand[15], operand};
    end else begin
      a_ext = {{9{signed_cmp & old8[7]}}, old8};
      b_ext = {{9{signed_cmp & operand[7]}}, operand[7:0]};
    end
  end

  assign a_lt_b = $signed(a_ext) < $signed(b_ext);

  always_comb begin
    unique case (op)
      AOP_ADD:  new_val = a_ext[15:0] + b_ext[15:0];
      AOP_SWAP: new_val = b_ext[15:0];
      AOP_XOR:  new_val = a_ext[15:0] ^ b_ext[15:0];
      AOP_AND:  new_val = a_ext[15:0] & b_ext[15:0];
      AOP_OR:   new_val = a_ext[15:0] | b_ext[15:0];
      AOP_MIN,
      AOP_MINU: new_val = a_lt_b ? a_ext[15:0] : b_ext[15:0];
      AOP_MAX,
      AOP_MAXU: new_val = a_lt_b ? b_ext[15:0] : a_ext[15:0];
      default:  new_val = a_ext[15:0];
    endcase
  end

  always_comb begin
    if (size == SZ_HALF) begin
      wstrb    = LANES'(2'b11) << offset;
      old_sext = {{(XLEN-16){old16[15]}}, old16};
    end else begin
      wstrb    = LANES'(1'b1) << offset;
      old_sext = {{(XLEN-8){old8[7]}}, old8};
    end
  end

  // Per-byte merge: an odd lane inside a halfword takes the upper result byte.
  for (genvar j = 0; j < LANES; j++) begin : g_merge
    logic [7:0] lane_new;
    assign lane_new = (size == SZ_HALF && j[0]) ? new_val[15:8] : new_val[7:0];
    assign wdata[8*j +: 8] = wstrb[j] ? lane_new : rdata[8*j +: 8];
  end

endmodule

// File: rtl/subword_amo_unit.sv
module subword_amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_enable,
  input  logic              req_valid,
  input  logic [31:0]       req_insn,
  input  logic [XLEN-1:0]   req_addr,
  input  logic [XLEN-1:0]   req_data,
  output logic              busy,
  output logic              mem_lock,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [XLEN-1:0]   mem_addr,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [XLEN/8-1:0] mem_strb,
  output logic              ord_acquire,
  output logic              ord_release,
  output logic              done,
  output logic [4:0]        rd_index,
  output logic [XLEN-1:0]   rd_value,
  output logic              fault_illegal,
  output logic              fault_misaligned
);

  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);

  amo_dec_t         dec;
  amo_state_e       state_q;
  amo_op_e          op_q;
  amo_size_e        size_q;
  logic [OFF_W-1:0] off_q;
  logic [15:0]      opnd_q;
  logic [XLEN-1:0]  old_sext;
  logic             misaligned;
  logic             accept;
  logic [XLEN-17:0] unused_opnd_high;

  assign unused_opnd_high = req_data[XLEN-1:16];

  amo_decode u_decode (
    .insn       (req_insn),
    .ext_enable (ext_enable),
    .dec        (dec)
  );

  assign misaligned = (dec.size == SZ_HALF) && req_addr[0];
  assign accept     = (state_q == ST_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q          <= ST_IDLE;
      op_q             <= AOP_ADD;
      size_q           <= SZ_BYTE;
      off_q            <= '0;
      opnd_q           <= '0;
      mem_addr         <= '0;
      rd_index         <= '0;
      rd_value         <= '0;
      ord_acquire      <= 1'b0;
      ord_release      <= 1'b0;
      fault_illegal    <= 1'b0;
      fault_misaligned <= 1'b0;
    end else begin
      fault_illegal    <= accept && !dec.legal;
      fault_misaligned <= accept && dec.legal && misaligned;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && dec.legal && !misaligned) begin
            state_q     <= ST_READ;
            op_q        <= dec.op;
            size_q      <= dec.size;
            off_q       <= req_addr[OFF_W-1:0];
            opnd_q      <= req_data[15:0];
            mem_addr    <= {req_addr[XLEN-1:OFF_W], {OFF_W{1'b0}}};
            rd_index    <= dec.rd;
            ord_acquire <= dec.acq;
            ord_release <= dec.rel;
          end
        end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: begin
          state_q  <= ST_DONE;
          rd_value <= old_sext;
        end
        ST_DONE: begin
          state_q     <= ST_IDLE;
          ord_acquire <= 1'b0;
          ord_release <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_rd_en = (state_q == ST_READ);
  assign mem_wr_en = (state_q == ST_WRITE);
  assign mem_lock  = mem_rd_en || mem_wr_en;
  assign done      = (state_q == ST_DONE);

  amo_lane_alu #(.XLEN(XLEN)) u_alu (
    .op       (op_q),
    .size     (size_q),
    .offset   (off_q),
    .rdata    (mem_rdata),
    .operand  (opnd_q),
    .wdata    (mem_wdata),
    .wstrb    (mem_strb),
    .old_sext (old_sext)
  );

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $past(mem_rd_en) && mem_lock); // R10
  AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_wr_en) && !mem_lock); // R10
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> mem_wr_en); // R10
  AST_DISABLED_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (accept && !ext_enable) |=> fault_illegal && !mem_rd_en); // R7
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (fault_illegal || fault_misaligned) |-> !mem_lock && !done); // R8
  AST_STRB_WIDTH: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $countones(mem_strb) == ((size_q == SZ_HALF) ? 2 : 1)); // R6
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && size_q == SZ_HALF) |-> (mem_strb[0] || !mem_strb[1])); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fault_illegal, fault_misaligned})); // R2

endmodule

// File: tb/subword_amo_unit_test.sv
`timescale 1ns/1ps
module subword_amo_unit_test;

  localparam int XLEN = 32;

  typedef struct packed {
    logic [4:0]  f5;
    logic [2:0]  f3;
    logic [1:0]  off;
    logic [31:0] rs2;
    logic [31:0] exp_rd;
    logic [31:0] exp_word;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] INIT = 32'hA57F_3C81;
  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{5'b00001, 3'b000, 2'd1, 32'h0000_00EE, 32'h0000_003C, 32'hA57F_EE81, 4'd3},
    '{5'b00000, 3'b000, 2'd0, 32'h0000_0090, 32'hFFFF_FF81, 32'hA57F_3C11, 4'd3},
    '{5'b00100, 3'b000, 2'd3, 32'h0000_00FF, 32'hFFFF_FFA5, 32'h5A7F_3C81, 4'd3},
    '{5'b01100, 3'b001, 2'd2, 32'h1234_0F0F, 32'hFFFF_A57F, 32'h050F_3C81, 4'd6},
    '{5'b01000, 3'b001, 2'd0, 32'hFFFF_4000, 32'h0000_3C81, 32'hA57F_7C81, 4'd6},
    '{5'b10000, 3'b000, 2'd0, 32'h0000_0005, 32'hFFFF_FF81, 32'hA57F_3C81, 4'd4},
    '{5'b10100, 3'b000, 2'd0, 32'h0000_0005, 32'hFFFF_FF81, 32'hA57F_3C05, 4'd4},
    '{5'b11000, 3'b000, 2'd0, 32'h0000_0005, 32'hFFFF_FF81, 32'hA57F_3C05, 4'd5},
    '{5'b11100, 3'b000, 2'd0, 32'h0000_0005, 32'hFFFF_FF81, 32'hA57F_3C81, 4'd5},
    '{5'b10000, 3'b001, 2'd2, 32'h0000_0001, 32'hFFFF_A57F, 32'hA57F_3C81, 4'd4},
    '{5'b11100, 3'b001, 2'd2, 32'h0000_FFFF, 32'hFFFF_A57F, 32'hFFFF_3C81, 4'd5},
    '{5'b10100, 3'b001, 2'd0, 32'h0000_8000, 32'h0000_3C81, 32'hA57F_3C81, 4'd4},
    '{5'b00000, 3'b001, 2'd2, 32'h0000_5A81, 32'hFFFF_A57F, 32'h0000_3C81, 4'd3},
    '{5'b11000, 3'b001, 2'd0, 32'hC000_3C80, 32'h0000_3C81, 32'hA57F_3C80, 4'd5},
    '{5'b00001, 3'b000, 2'd2, 32'h1234_5600, 32'h0000_007F, 32'hA500_3C81, 4'd2},
    '{5'b11100, 3'b000, 2'd1, 32'h0000_00C0, 32'h0000_003C, 32'hA57F_C081, 4'd5}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ext_enable = 1'b1;
  logic              req_valid = 1'b0;
  logic [31:0]       req_insn = '0;
  logic [XLEN-1:0]   req_addr = '0;
  logic [XLEN-1:0]   req_data = '0;
  logic              busy, mem_lock, mem_rd_en, mem_wr_en, done;
  logic [XLEN-1:0]   mem_addr, mem_rdata, mem_wdata, rd_value;
  logic [XLEN/8-1:0] mem_strb;
  logic              ord_acquire, ord_release, fault_illegal, fault_misaligned;
  logic [4:0]        rd_index;

  int tests = 0;
  int fails = 0;

  logic [31:0] mem [16];
  logic        pl_en = 1'b0;
  logic [3:0]  pl_idx = '0;
  logic [31:0] pl_data = '0;
  int          rd_events = 0;
  int          wr_events = 0;
  logic [3:0]  last_strb = '0;

  always #10 clk = ~clk;

  subword_amo_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .ext_enable(ext_enable), .req_valid(req_valid),
    .req_insn(req_insn), .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .mem_lock(mem_lock), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_strb(mem_strb), .ord_acquire(ord_acquire), .ord_release(ord_release),
    .done(done), .rd_index(rd_index), .rd_value(rd_value),
    .fault_illegal(fault_illegal), .fault_misaligned(fault_misaligned)
  );

  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_data;
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr[5:2]];
      rd_events <= rd_events + 1;
    end
    if (mem_wr_en) begin
      for (int b = 0; b < 4; b++)
        if (mem_strb[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      wr_events <= wr_events + 1;
      last_strb <= mem_strb;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = idx; pl_data = val;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  // Issue one request and follow it to its end. Records the cycle of each event.
  int rd_cyc, wr_cyc, done_cyc, lock_cycles, ill_seen, mis_seen, acq_at_done, rel_at_done;
  logic [31:0] got_rd;
  logic [4:0]  got_idx;
  task automatic issue(input logic [31:0] insn, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_insn = insn; req_addr = addr; req_data = data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rd_cyc = -1; wr_cyc = -1; done_cyc = -1; lock_cycles = 0;
    ill_seen = 0; mis_seen = 0; acq_at_done = 0; rel_at_done = 0;
    got_rd = '0; got_idx = '0;
    for (int k = 0; k < 8; k++) begin
      if (mem_rd_en) rd_cyc = k;
      if (mem_wr_en) wr_cyc = k;
      if (mem_lock) lock_cycles++;
      if (fault_illegal) ill_seen++;
      if (fault_misaligned) mis_seen++;
      if (done) begin
        done_cyc = k; got_rd = rd_value; got_idx = rd_index;
        acq_at_done = ord_acquire; rel_at_done = ord_release;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] f5, input logic aq, input logic rl,
                                     input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] opc);
    return {f5, aq, rl, 5'd2, 5'd1, f3, rd, opc};
  endfunction

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "outputs in reset", {26'd0, busy, done, mem_lock, mem_rd_en, mem_wr_en, fault_illegal | fault_misaligned}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R11", "outputs after reset", {26'd0, busy, done, mem_lock, mem_rd_en, mem_wr_en, fault_illegal | fault_misaligned}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int w0;
      logic [3:0] exp_strb;
      logic aq, rl;
      v = VECS[i];
      aq = i[0]; rl = i[1];
      preload(4'd3, INIT);
      w0 = wr_events;
      exp_strb = (v.f3 == 3'b000) ? (4'b0001 << v.off) : (4'b0011 << v.off);
      issue(mk(v.f5, aq, rl, v.f3, 5'(i + 1), 7'b0101111), 32'h0000_000C + 32'(v.off), v.rs2);
      chk(rname(v.req), "rd value", got_rd, v.exp_rd);
      chk(rname(v.req), "memory word", mem[3], v.exp_word);
      chk("R6", "write strobes", {28'd0, last_strb}, {28'd0, exp_strb});
      chk("R2", "rd index", {27'd0, got_idx}, 32'(i + 1));
      chk("R1", "order bits at done", {30'd0, acq_at_done[0], rel_at_done[0]}, {30'd0, aq, rl});
      chk("R10", "single write", 32'(wr_events - w0), 32'd1);
    end

    // R10: cycle sequence of an accepted request
    preload(4'd3, INIT);
    issue(mk(5'b00000, 1'b0, 1'b0, 3'b000, 5'd9, 7'b0101111), 32'h0000_000C, 32'h1);
    chk("R10", "read cycle", 32'(rd_cyc), 32'd0);
    chk("R10", "write cycle", 32'(wr_cyc), 32'd1);
    chk("R10", "done cycle", 32'(done_cyc), 32'd2);
    chk("R10", "lock cycles", 32'(lock_cycles), 32'd2);
    chk("R10", "idle after done", {30'd0, busy, done}, 32'd0);

    // R7: extension disabled
    preload(4'd3, INIT);
    ext_enable = 1'b0;
    begin
      int r0, w0;
      r0 = rd_events; w0 = wr_events;
      issue(mk(5'b00001, 1'b0, 1'b0, 3'b000, 5'd4, 7'b0101111), 32'h0000_000C, 32'hFF);
      chk("R7", "illegal pulses", 32'(ill_seen), 32'd1);
      chk("R7", "memory accesses", 32'((rd_events - r0) + (wr_events - w0)), 32'd0);
      chk("R7", "no done", 32'(done_cyc), 32'hFFFF_FFFF);
      chk("R7", "memory intact", mem[3], INIT);
    end
    ext_enable = 1'b1;

    // R8: unlisted funct5, funct3, and opcode
    begin
      int r0;
      r0 = rd_events;
      issue(mk(5'b11111, 1'b0, 1'b0, 3'b000, 5'd4, 7'b0101111), 32'h0000_000C, 32'h1);
      chk("R8", "bad funct5 illegal", 32'(ill_seen), 32'd1);
      issue(mk(5'b00000, 1'b0, 1'b0, 3'b010, 5'd4, 7'b0101111), 32'h0000_000C, 32'h1);
      chk("R8", "bad funct3 illegal", 32'(ill_seen), 32'd1);
      issue(mk(5'b00000, 1'b0, 1'b0, 3'b000, 5'd4, 7'b0110011), 32'h0000_000C, 32'h1);
      chk("R8", "bad opcode illegal", 32'(ill_seen), 32'd1);
      chk("R8", "no reads", 32'(rd_events - r0), 32'd0);
      chk("R8", "memory intact", mem[3], INIT);
    end

    // R9: odd halfword addresses fault; byte at odd address does not
    begin
      int r0;
      r0 = rd_events;
      issue(mk(5'b00001, 1'b0, 1'b0, 3'b001, 5'd4, 7'b0101111), 32'h0000_000D, 32'hFFFF);
      chk("R9", "offset 1 misaligned", 32'(mis_seen), 32'd1);
      chk("R9", "offset 1 no done", 32'(done_cyc), 32'hFFFF_FFFF);
      issue(mk(5'b00001, 1'b0, 1'b0, 3'b001, 5'd4, 7'b0101111), 32'h0000_000F, 32'hFFFF);
      chk("R9", "offset 3 misaligned", 32'(mis_seen), 32'd1);
      chk("R9", "no accesses", 32'(rd_events - r0), 32'd0);
      chk("R9", "memory intact", mem[3], INIT);
      issue(mk(5'b00001, 1'b0, 1'b0, 3'b000, 5'd4, 7'b0101111), 32'h0000_000F, 32'h11);
      chk("R9", "byte odd accepted", 32'(mis_seen), 32'd0);
      chk("R9", "byte odd result", mem[3], 32'h117F_3C81);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule